// File: doc/BRIEF.md
# USB OTG Session Request Sequencer (B-device side)

This block is the protocol engine a B-device uses to ask a powered-down host for a new bus session. While the device is connected it measures how long the bus has been quiet. After a full idle interval it raises an early-suspend flag. After a short further gap it raises a suspend flag and asks the PHY to drain VBUS. It then waits for the PHY to report that the session has ended. It releases the D+ pull-up and requires an unbroken run of SE0 before it reports that a request may be made.

Software starts the request with a one-cycle write strobe. The block drives a D+ pull-up pulse first and a VBUS charge pulse second, then waits a bounded time for the host to power the bus. If VBUS becomes valid, the block records success, flags a status change and reconnects. If the wait runs out, it flags a failure and goes back to the SE0 guard. Every interval is counted in ticks of a one-per-microsecond enable input, so the clock frequency does not affect the protocol timing.

States: `ST_RUN` (connected, idle count), `ST_ESUSP` (early suspend seen), `ST_DISCHG` (VBUS drain requested), `ST_SE0WAIT` (SE0 guard), `ST_READY` (request allowed), `ST_DPULSE` (D+ pulse), `ST_VPULSE` (VBUS pulse), `ST_WAITV` (awaiting VBUS).

Transitions:
- RUN→ESUSP when the idle interval completes.
- ESUSP→DISCHG when the gap completes.
- RUN, ESUSP or DISCHG go back to RUN on bus activity.
- DISCHG→SE0WAIT on session end.
- SE0WAIT→READY when the SE0 guard completes.
- READY→SE0WAIT when the line leaves SE0.
- READY→DPULSE on a request write.
- DPULSE→VPULSE and VPULSE→WAITV when each pulse completes.
- DPULSE, VPULSE or WAITV go to RUN (success) on VBUS valid.
- WAITV→SE0WAIT (failure) on timeout.
- SE0WAIT or READY go to RUN when VBUS becomes valid without a request.

Top module: `srp_seq`

## Requirements
- R1: After reset, `dp_pullup` is 1. `dischrg_vbus`, `chrg_vbus`, `srp_ready`, `srp_req`, `srp_ok` and all four `irq` bits are 0.
- R2: Bus idle means line state J (01) or SE0 (00). After IDLE_MS*US_PER_MS consecutive idle ticks, `irq[0]` (early suspend) is set. SUSP_GAP_US ticks later, `irq[1]` (suspend) is set and `dischrg_vbus` is asserted, with `dp_pullup` still 1.
- R3: Bus activity means line state K (10) or SE1 (11). Activity before suspend restarts the idle count and returns the block to the connected state, so no suspend flag appears and `dischrg_vbus` stays 0.
- R4: `dischrg_vbus` stays asserted until `sess_end` is 1. It is then released together with `dp_pullup`. `dischrg_vbus` and `chrg_vbus` are never 1 at the same time.
- R5: After session end, `srp_ready` rises only after SE0_MS*US_PER_MS consecutive ticks of line state SE0 (00). Any other line state restarts that count, and in the ready state it drops `srp_ready`.
- R6: A `req_wr` strobe starts a request only while `srp_ready` is 1. At any other time it is ignored: `srp_req` stays 0 and no pulse is driven.
- R7: A request drives `dp_pullup` for DP_PULSE_US ticks, then `chrg_vbus` for VB_PULSE_US ticks, never overlapping and never in the reverse order. `srp_req` stays 1 until the request ends.
- R8: `vbus_valid` during the D+ pulse, the VBUS pulse or the wait sets `srp_ok` and `irq[2]`, clears `srp_req` and holds `dp_pullup` at 1. If this happens during the D+ pulse, `chrg_vbus` is never asserted. `srp_ok` is cleared when a new request starts.
- R9: If VBUS is not valid within TIMEOUT_US ticks after the VBUS pulse, `irq[3]` is set, `srp_ok` and `srp_req` are 0, and the SE0 guard restarts.
- R10: A 1 in bit i of `irq_clr` clears `irq[i]`. Bits written 0 are unchanged, and `srp_ok` is unaffected.
- R11: Every interval is counted in `tick_us` pulses, not clock cycles. A tick every P cycles stretches the idle interval to P times as many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle microsecond enable |
| line_state | input | 2 | Bus line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| vbus_valid | input | 1 | PHY reports VBUS valid |
| sess_end | input | 1 | PHY reports session end |
| req_wr | input | 1 | Software write of the session-request bit |
| irq_clr | input | 4 | Write-one-to-clear strobes for `irq` |
| dischrg_vbus | output | 1 | Request to PHY to discharge VBUS |
| chrg_vbus | output | 1 | Request to PHY to charge VBUS (VBUS pulse) |
| dp_pullup | output | 1 | D+ pull-up enable |
| srp_ready | output | 1 | Preconditions met, request may be written |
| srp_req | output | 1 | Session-request bit, self-clearing |
| srp_ok | output | 1 | Session request succeeded |
| irq | output | 4 | Flags: 0 early suspend, 1 suspend, 2 success change, 3 failure change |

## Verification
The bench sweeps the moment a K state breaks the idle count across the whole window. A design that failed to restart the count would suspend early, at a cycle count below the idle interval. It restarts the SE0 guard with a J state and with a request write landing mid-count, which would show a premature `srp_ready` or an accepted request. It traces the D+ and VBUS pulses cycle by cycle up to timeout, so swapped, overlapped or off-by-one pulses are caught. It also ends a request by a VBUS arrival during the D+ pulse, where a design that still charged VBUS would be caught. Tick-period sweeps expose a design that counts clocks instead of microseconds.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ESUSP,
        ST_DISCHG,
        ST_SE0WAIT,
        ST_READY,
        ST_DPULSE,
        ST_VPULSE,
        ST_WAITV
    } srp_state_e;

    localparam logic [1:0] LS_SE0 = 2'b00;
    localparam logic [1:0] LS_J   = 2'b01;
    localparam logic [1:0] LS_K   = 2'b10;
    localparam logic [1:0] LS_SE1 = 2'b11;

    localparam int IRQ_EARLY = 0;
    localparam int IRQ_SUSP  = 1;
    localparam int IRQ_OK    = 2;
    localparam int IRQ_FAIL  = 3;
    localparam int IRQ_N     = 4;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srp_linemon.sv
module srp_linemon
    import srp_pkg::*;
(
    input  logic [1:0] line_state,
    output logic       is_se0,
    output logic       is_act
);

    always_comb begin
        is_se0 = 1'b0;
        is_act = 1'b0;
        unique case (line_state)
            LS_SE0: is_se0 = 1'b1;
            LS_J:   is_act = 1'b0;
            LS_K:   is_act = 1'b1;
            LS_SE1: is_act = 1'b1;
            default: is_act = 1'b0;
        endcase
    end

endmodule

// File: rtl/srp_timer.sv
module srp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // done does not depend on clr, so the FSM may derive clr from done
    assign done = tick && (cnt_q == limit - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= done ? '0 : cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/srp_irq.sv
module srp_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/srp_seq.sv
module srp_seq
    import srp_pkg::*;
#(
    parameter int US_PER_MS   = 1000,
    parameter int IDLE_MS     = 3,
    parameter int SE0_MS      = 2,
    parameter int SUSP_GAP_US = 1000,
    parameter int DP_PULSE_US = 6000,
    parameter int VB_PULSE_US = 20000,
    parameter int TIMEOUT_US  = 5000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_us,
    input  logic [1:0]       line_state,
    input  logic             vbus_valid,
    input  logic             sess_end,
    input  logic             req_wr,
    input  logic [IRQ_N-1:0] irq_clr,
    output logic             dischrg_vbus,
    output logic             chrg_vbus,
    output logic             dp_pullup,
    output logic             srp_ready,
    output logic             srp_req,
    output logic             srp_ok,
    output logic [IRQ_N-1:0] irq
);

    localparam int L_IDLE = IDLE_MS * US_PER_MS;
    localparam int L_SE0  = SE0_MS * US_PER_MS;
    localparam int L_MAX  = imax(imax(imax(L_IDLE, L_SE0), imax(SUSP_GAP_US, DP_PULSE_US)),
                                 imax(VB_PULSE_US, TIMEOUT_US));
    localparam int TW     = $clog2(L_MAX + 1);

    srp_state_e state_q, state_d;

    logic          is_se0, is_act;
    logic          tmr_clr, tmr_done, restart;
    logic [TW-1:0] tmr_limit;
    logic [IRQ_N-1:0] irq_set;
    logic          start_req, req_ok, req_fail;
    logic          req_q, ok_q;

    srp_linemon u_line (
        .line_state (line_state),
        .is_se0     (is_se0),
        .is_act     (is_act)
    );

    srp_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tick_us),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    srp_irq #(.N(IRQ_N)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (irq_clr),
        .flags (irq)
    );

    // interval selected by the current state
    always_comb begin
        unique case (state_q)
            ST_RUN:     tmr_limit = TW'(L_IDLE);
            ST_ESUSP:   tmr_limit = TW'(SUSP_GAP_US);
            ST_SE0WAIT: tmr_limit = TW'(L_SE0);
            ST_DPULSE:  tmr_limit = TW'(DP_PULSE_US);
            ST_VPULSE:  tmr_limit = TW'(VB_PULSE_US);
            ST_WAITV:   tmr_limit = TW'(TIMEOUT_US);
            default:    tmr_limit = TW'(L_IDLE);
        endcase
    end

    // next state and event pulses
    always_comb begin
        state_d   = state_q;
        restart   = 1'b0;
        irq_set   = '0;
        start_req = 1'b0;
        req_ok    = 1'b0;
        req_fail  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (is_act) begin
                    restart = 1'b1;
                end else if (tmr_done) begin
                    state_d            = ST_ESUSP;
                    irq_set[IRQ_EARLY] = 1'b1;
                end
            end
            ST_ESUSP: begin
                if (is_act) begin
                    state_d = ST_RUN;
                end else if (tmr_done) begin
                    state_d           = ST_DISCHG;
                    irq_set[IRQ_SUSP] = 1'b1;
                end
            end
            ST_DISCHG: begin
                if (is_act) begin
                    state_d = ST_RUN;
                end else if (sess_end) begin
                    state_d = ST_SE0WAIT;
                end
            end
            ST_SE0WAIT: begin
                if (vbus_valid) begin
                    state_d = ST_RUN;
                end else if (!is_se0) begin
                    restart = 1'b1;
                end else if (tmr_done) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                if (vbus_valid) begin
                    state_d = ST_RUN;
                end else if (!is_se0) begin
                    state_d = ST_SE0WAIT;
                end else if (req_wr) begin
                    state_d   = ST_DPULSE;
                    start_req = 1'b1;
                end
            end
            ST_DPULSE: begin
                if (vbus_valid) begin
                    state_d = ST_RUN;
                    req_ok  = 1'b1;
                end else if (tmr_done) begin
                    state_d = ST_VPULSE;
                end
            end
            ST_VPULSE: begin
                if (vbus_valid) begin
                    state_d = ST_RUN;
                    req_ok  = 1'b1;
                end else if (tmr_done) begin
                    state_d = ST_WAITV;
                end
            end
            ST_WAITV: begin
                if (vbus_valid) begin
                    state_d = ST_RUN;
                    req_ok  = 1'b1;
                end else if (tmr_done) begin
                    state_d  = ST_SE0WAIT;
                    req_fail = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
        irq_set[IRQ_OK]   = req_ok;
        irq_set[IRQ_FAIL] = req_fail;
        tmr_clr = restart || (state_d != state_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // request and success bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            ok_q  <= 1'b0;
        end else begin
            if (start_req) begin
                req_q <= 1'b1;
                ok_q  <= 1'b0;
            end else if (req_ok) begin
                req_q <= 1'b0;
                ok_q  <= 1'b1;
            end else if (req_fail) begin
                req_q <= 1'b0;
                ok_q  <= 1'b0;
            end
        end
    end

    // PHY controls decoded from state
    always_comb begin
        dischrg_vbus = 1'b0;
        chrg_vbus    = 1'b0;
        dp_pullup    = 1'b0;
        srp_ready    = 1'b0;
        unique case (state_q)
            ST_RUN:     dp_pullup = 1'b1;
            ST_ESUSP:   dp_pullup = 1'b1;
            ST_DISCHG: begin
                dp_pullup    = 1'b1;
                dischrg_vbus = 1'b1;
            end
            ST_SE0WAIT: dp_pullup = 1'b0;
            ST_READY:   srp_ready = 1'b1;
            ST_DPULSE:  dp_pullup = 1'b1;
            ST_VPULSE:  chrg_vbus = 1'b1;
            ST_WAITV:   chrg_vbus = 1'b0;
            default:    dp_pullup = 1'b0;
        endcase
    end

    assign srp_req = req_q;
    assign srp_ok  = ok_q;

endmodule

// File: rtl/srp_seq_chk.sv
module srp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_wr,
    input logic       vbus_valid,
    input logic [1:0] line_state,
    input logic       dischrg_vbus,
    input logic       chrg_vbus,
    input logic       dp_pullup,
    input logic       srp_ready,
    input logic       srp_req,
    input logic       srp_ok,
    input logic [3:0] irq
);

    AST_DISCH_WITH_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dischrg_vbus) |-> irq[1]); // R2

    AST_NO_DUAL_VBUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(dischrg_vbus && chrg_vbus)); // R4

    AST_READY_AFTER_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        srp_ready |-> ($past(line_state) == 2'b00)); // R5

    AST_REQ_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srp_req) |-> ($past(srp_ready) && $past(req_wr))); // R6

    AST_CHRG_AFTER_DP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chrg_vbus) |-> ($past(dp_pullup) && !dp_pullup)); // R7

    AST_CHRG_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        chrg_vbus |-> srp_req); // R7

    AST_OK_ON_VBUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srp_ok) |-> ($past(vbus_valid) && !srp_req && dp_pullup)); // R8

    AST_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[3]) |-> (!srp_ok && !srp_req)); // R9

endmodule

bind srp_seq srp_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_wr       (req_wr),
    .vbus_valid   (vbus_valid),
    .line_state   (line_state),
    .dischrg_vbus (dischrg_vbus),
    .chrg_vbus    (chrg_vbus),
    .dp_pullup    (dp_pullup),
    .srp_ready    (srp_ready),
    .srp_req      (srp_req),
    .srp_ok       (srp_ok),
    .irq          (irq)
);

// File: tb/srp_seq_test.sv
`timescale 1ns/1ps
module srp_seq_test;

    localparam int UPM = 4;
    localparam int IDM = 3;
    localparam int SEM = 2;
    localparam int GAP = 3;
    localparam int DPW = 2;
    localparam int VBW = 3;
    localparam int TOW = 5;
    localparam int L_IDLE = IDM * UPM;
    localparam int L_SE0  = SEM * UPM;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b1;
    logic [1:0] line_state = 2'b01;
    logic       vbus_valid = 1'b1;
    logic       sess_end = 1'b0;
    logic       req_wr = 1'b0;
    logic [3:0] irq_clr = 4'b0;
    logic       dischrg_vbus, chrg_vbus, dp_pullup, srp_ready, srp_req, srp_ok;
    logic [3:0] irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    srp_seq #(
        .US_PER_MS(UPM), .IDLE_MS(IDM), .SE0_MS(SEM), .SUSP_GAP_US(GAP),
        .DP_PULSE_US(DPW), .VB_PULSE_US(VBW), .TIMEOUT_US(TOW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .line_state(line_state),
        .vbus_valid(vbus_valid), .sess_end(sess_end), .req_wr(req_wr),
        .irq_clr(irq_clr), .dischrg_vbus(dischrg_vbus), .chrg_vbus(chrg_vbus),
        .dp_pullup(dp_pullup), .srp_ready(srp_ready), .srp_req(srp_req),
        .srp_ok(srp_ok), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic sel(input int w);
        case (w)
            0: return irq[0];
            1: return irq[1];
            2: return srp_ready;
            default: return irq[3];
        endcase
    endfunction

    // cycles until the selected output rises, with a tick every per cycles
    task automatic measure(input int w, input int per, output int n);
        n = 0;
        while (n < 2000) begin
            tick_us = ((n % per) == per - 1);
            step();
            n++;
            if (sel(w)) break;
        end
        tick_us = 1'b1;
    endtask

    task automatic clear_irq();
        irq_clr = 4'hF;
        step();
        irq_clr = 4'h0;
    endtask

    task automatic kick();
        line_state = 2'b10;
        step();
        line_state = 2'b01;
    endtask

    task automatic go_suspend();
        int n;
        vbus_valid = 1'b1;
        sess_end   = 1'b0;
        clear_irq();
        kick();
        measure(0, 1, n);
        chk("R2 idle interval", n, L_IDLE);
        measure(1, 1, n);
        chk("R2 suspend gap", n, GAP);
        chk("R2 discharge on suspend", dischrg_vbus, 1);
    endtask

    task automatic go_ready();
        int n;
        vbus_valid = 1'b0;
        sess_end   = 1'b1;
        line_state = 2'b00;
        step();
        chk("R4 discharge released", dischrg_vbus, 0);
        chk("R4 pullup released", dp_pullup, 0);
        measure(2, 1, n);
        chk("R5 SE0 guard", n, L_SE0);
    endtask

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 pullup", dp_pullup, 1);
        chk("R1 controls", {dischrg_vbus, chrg_vbus, srp_ready, srp_req, srp_ok}, 0);
        chk("R1 irq", irq, 0);

        // R3 activity at every point of the idle window
        for (int p = 0; p < L_IDLE; p++) begin
            clear_irq();
            kick();
            repeat (p) step();
            chk("R3 no early flag", irq[0], 0);
            kick();
            measure(0, 1, n);
            chk("R3 restart then idle", n, L_IDLE);
            kick();
            repeat (GAP + 1) step();
            chk("R3 no suspend from early", irq[1], 0);
            chk("R3 no discharge", dischrg_vbus, 0);
        end

        // R11 tick period sweep
        for (int per = 2; per <= 4; per++) begin
            clear_irq();
            kick();
            measure(0, per, n);
            chk("R11 ticks not cycles", n, L_IDLE * per);
            kick();
        end

        // R2, R4 suspend and discharge hold
        go_suspend();
        chk("R2 pullup held", dp_pullup, 1);
        repeat (20) step();
        chk("R4 discharge held", dischrg_vbus, 1);
        chk("R4 no ready", srp_ready, 0);
        kick();
        chk("R3 activity ends discharge", dischrg_vbus, 0);
        go_suspend();
        go_ready();

        // R5 restart in ready and mid-count, R6 ignored write
        line_state = 2'b01;
        step();
        chk("R5 ready dropped", srp_ready, 0);
        line_state = 2'b00;
        measure(2, 1, n);
        chk("R5 restart from ready", n, L_SE0);
        line_state = 2'b10;
        step();
        line_state = 2'b00;
        repeat (3) step();
        line_state = 2'b01;
        step();
        line_state = 2'b00;
        req_wr = 1'b1;
        step();
        req_wr = 1'b0;
        chk("R6 write ignored", srp_req, 0);
        chk("R6 no pulse", {dp_pullup, chrg_vbus}, 0);
        measure(2, 1, n);
        chk("R5 restart mid-count", n, L_SE0 - 1);

        // R7, R9 full pulse trace up to timeout
        req_wr = 1'b1;
        for (int k = 1; k <= DPW + VBW + TOW + 1; k++) begin
            step();
            req_wr = 1'b0;
            chk("R7 dp pulse", dp_pullup, (k <= DPW) ? 1 : 0);
            chk("R7 vbus pulse", chrg_vbus, (k > DPW && k <= DPW + VBW) ? 1 : 0);
            chk("R7 request held", srp_req, (k <= DPW + VBW + TOW) ? 1 : 0);
        end
        chk("R9 fail flag", irq[3], 1);
        chk("R9 ok cleared", srp_ok, 0);
        measure(2, 1, n);
        chk("R9 guard restarted", n, L_SE0);

        // R8 success during VBUS pulse
        req_wr = 1'b1;
        step();
        req_wr = 1'b0;
        repeat (DPW) step();
        chk("R7 in vbus pulse", chrg_vbus, 1);
        vbus_valid = 1'b1;
        sess_end   = 1'b0;
        line_state = 2'b01;
        step();
        chk("R8 ok", srp_ok, 1);
        chk("R8 change flag", irq[2], 1);
        chk("R8 req cleared", srp_req, 0);
        chk("R8 connected", dp_pullup, 1);
        chk("R8 charge off", chrg_vbus, 0);

        // R10 write-one-to-clear
        irq_clr = 4'b1000;
        step();
        irq_clr = 4'b0;
        chk("R10 fail cleared", irq[3], 0);
        chk("R10 ok change kept", irq[2], 1);
        irq_clr = 4'b0100;
        step();
        irq_clr = 4'b0;
        chk("R10 ok change cleared", irq[2], 0);
        chk("R10 ok status kept", srp_ok, 1);

        // R8 success during D+ pulse
        go_suspend();
        go_ready();
        req_wr = 1'b1;
        step();
        req_wr = 1'b0;
        chk("R8 ok cleared at start", srp_ok, 0);
        chk("R7 dp first", {dp_pullup, chrg_vbus}, 2);
        vbus_valid = 1'b1;
        sess_end   = 1'b0;
        line_state = 2'b01;
        step();
        chk("R8 ok from dp pulse", srp_ok, 1);
        chk("R8 no charge", chrg_vbus, 0);
        repeat (3) step();
        chk("R8 steady connect", {dp_pullup, chrg_vbus}, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog (all requirements): actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule